// File: doc/BRIEF.md
# Two-Wire Wiper Command Target

This block is a two-wire serial target (I2C-compatible) that sits in front of an 8-bit resistive wiper and its fuse-programming logic. SCL and SDA are sampled with the system clock; each line passes through a two-flop synchronizer and a three-tap majority vote before START, STOP and clock edges are found. The target answers to a 7-bit address whose upper five bits are fixed at `01011` and whose two low bits come from strap pins, so four targets can share one bus.

A write frame is the address byte, then an instruction byte, then any number of data bytes. The instruction byte sets four command fields and produces a one-cycle instruction strobe; every data byte that follows in the same frame produces a one-cycle data strobe carrying the byte. A read frame returns the current wiper value, then a status byte holding the two fuse validation bits, and repeats that pair for as long as the master acknowledges.

The data path out of the block is a valid-only stream: `wdata_valid_o` is high for exactly one cycle per byte and there is no ready input. The bus has no clock stretching, so there is no back-pressure; the consumer must take every strobe in the cycle it appears. Bytes arrive no faster than one per nine SCL periods. The system clock must run at least 16 times the SCL rate.

Top module: `wiper_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal {0,1,0,1,1,addr_pins_i[1],addr_pins_i[0]}; on a mismatch it drives no ACK and ignores every following bit until the next START or STOP.
- R2: A write instruction byte with bit 4 clear is acknowledged and loads trim_sel_o from bit 7, shutdown_o from bit 6, fuse_prog_o from bit 5 and overwrite_o from bit 3 (bits 2..0 ignored), with instr_valid_o high for one cycle; the four fields change in no other cycle.
- R3: A write instruction byte with bit 4 set is still acknowledged, but raises no instruction strobe, leaves the four fields unchanged and raises no data strobe for the rest of that frame.
- R4: Every data byte after an accepted instruction byte is acknowledged and produces wdata_valid_o for exactly one cycle with wdata_o equal to the byte, until STOP.
- R5: After a read address, the target sends wiper_i MSB first, then the status byte {status_i[1], status_i[0], 000000} (status_i[1] in bit 7, status_i[0] in bit 6); while the master acknowledges it keeps alternating wiper and status, sampling wiper_i afresh for each wiper byte; a master NACK ends the transfer and the line is released.
- R6: A START or STOP in the middle of a byte discards the partial byte with no strobe; a START always begins a new address byte.
- R7: sda_pull_o is high only during a target ACK bit or a zero bit of a read byte, is low the cycle after a STOP, and changes only while the filtered SCL is low.
- R8: A pulse of one system-clock cycle on SCL or SDA is ignored: no clock edge, START or STOP is seen from it.
- R9: After reset sda_pull_o, both strobes, the four command fields and wdata_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA |
| addr_pins_i | input | 2 | Strapped low two address bits |
| wiper_i | input | 8 | Current wiper value returned in reads |
| status_i | input | 2 | Fuse validation bits, [1] to byte bit 7, [0] to byte bit 6 |
| trim_sel_o | output | 1 | Trim-array select field |
| shutdown_o | output | 1 | Shutdown field |
| fuse_prog_o | output | 1 | Permanent-program request field |
| overwrite_o | output | 1 | Temporary overwrite field |
| instr_valid_o | output | 1 | One-cycle strobe when an instruction byte is accepted |
| wdata_o | output | 8 | Last wiper data byte received |
| wdata_valid_o | output | 1 | One-cycle strobe per received data byte |

## Verification
The bench sweeps every upper address pattern against each strap setting, since a target that compares too few bits would acknowledge a neighbour's address and corrupt its frame. It walks all 32 upper-five-bit instruction patterns, where a design that ignored bit 4 would emit strobes for a reserved command, and multi-byte writes, where one that stopped after the first data byte would drop wiper updates. Reads cycle through all four status codes and a changing wiper, exposing swapped status bits or a stale wiper. START and STOP inside a byte, and single-cycle glitches on both lines, would show as spurious strobes or lost bytes in a design that skipped the abort or the vote.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] DEV_ADDR_HI = 5'b01011;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_SKIP
  } bus_st_e;

  typedef enum logic [1:0] {
    BY_ADDR, BY_INSTR, BY_DATA
  } byte_kind_e;
endpackage

// File: rtl/pot_line_filter.sv
module pot_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW   = $clog2(VOTE_TAPS + 1);
  localparam int HALF = VOTE_TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   hist_q;
  logic [CW-1:0]          ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_TAPS; i++) ones = ones + CW'(hist_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      clean_o <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_i};
      hist_q  <= {hist_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      clean_o <= (ones > CW'(HALF));
    end
  end

  // R8
  vote_follows_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_o != $past(clean_o)) |-> (clean_o == $past(hist_q[0])));
endmodule

// File: rtl/pot_bus_cond.sv
module pot_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/wiper_i2c_target.sv
module wiper_i2c_target
  import wiper_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [1:0]        addr_pins_i,
  input  logic [BYTE_W-1:0] wiper_i,
  input  logic [1:0]        status_i,
  output logic              trim_sel_o,
  output logic              shutdown_o,
  output logic              fuse_prog_o,
  output logic              overwrite_o,
  output logic              instr_valid_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              wdata_valid_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [1:0] raw_lines, clean_lines;
  logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    pot_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_lines[g]), .clean_o(clean_lines[g]));
  end

  assign scl_f = clean_lines[1];
  assign sda_f = clean_lines[0];

  pot_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev));

  bus_st_e           st_q;
  byte_kind_e        kind_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rd_q, frame_ok_q, next_status_q, nack_q;
  logic [BYTE_W-1:0] status_byte;

  assign status_byte = {status_i, {(BYTE_W-2){1'b0}}};
  assign sda_pull_o  = (st_q == ST_ACK) || ((st_q == ST_TX) && !tx_q[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      kind_q        <= BY_ADDR;
      rx_q          <= '0;
      tx_q          <= '1;
      cnt_q         <= '0;
      rd_q          <= 1'b0;
      frame_ok_q    <= 1'b0;
      next_status_q <= 1'b0;
      nack_q        <= 1'b1;
      trim_sel_o    <= 1'b0;
      shutdown_o    <= 1'b0;
      fuse_prog_o   <= 1'b0;
      overwrite_o   <= 1'b0;
      instr_valid_o <= 1'b0;
      wdata_o       <= '0;
      wdata_valid_o <= 1'b0;
    end else begin
      instr_valid_o <= 1'b0;
      wdata_valid_o <= 1'b0;
      if (start_ev) begin
        st_q       <= ST_RX;
        kind_q     <= BY_ADDR;
        cnt_q      <= '0;
        frame_ok_q <= 1'b0;
      end else if (stop_ev) begin
        st_q       <= ST_IDLE;
        frame_ok_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_f};
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
              cnt_q <= '0;
              unique case (kind_q)
                BY_ADDR: begin
                  if (rx_q[BYTE_W-1:1] == {DEV_ADDR_HI, addr_pins_i}) begin
                    rd_q <= rx_q[0];
                    st_q <= ST_ACK;
                  end else begin
                    st_q <= ST_SKIP;
                  end
                end
                BY_INSTR: begin
                  st_q <= ST_ACK;
                  if (!rx_q[4]) begin
                    trim_sel_o    <= rx_q[7];
                    shutdown_o    <= rx_q[6];
                    fuse_prog_o   <= rx_q[5];
                    overwrite_o   <= rx_q[3];
                    instr_valid_o <= 1'b1;
                    frame_ok_q    <= 1'b1;
                  end
                end
                default: begin
                  st_q <= ST_ACK;
                  if (frame_ok_q) begin
                    wdata_o       <= rx_q;
                    wdata_valid_o <= 1'b1;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (kind_q == BY_ADDR && rd_q) begin
                st_q          <= ST_TX;
                tx_q          <= wiper_i;
                next_status_q <= 1'b1;
              end else begin
                st_q   <= ST_RX;
                kind_q <= (kind_q == BY_ADDR) ? BY_INSTR : BY_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
              if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                cnt_q <= '0;
                st_q  <= ST_MACK;
              end else begin
                cnt_q <= cnt_q + CNT_W'(1);
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              nack_q <= sda_f;
            end else if (scl_fall) begin
              if (nack_q) begin
                st_q <= ST_SKIP;
              end else begin
                st_q          <= ST_TX;
                tx_q          <= next_status_q ? status_byte : wiper_i;
                next_status_q <= ~next_status_q;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_pull_o);

  // R7
  pull_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_pull_o));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({instr_valid_o, wdata_valid_o}));

  // R4
  data_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_valid_o |=> !wdata_valid_o);

  // R2
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({trim_sel_o, shutdown_o, fuse_prog_o, overwrite_o}) |-> instr_valid_o);
endmodule

// File: tb/test_wiper_i2c_target.sv
module test_wiper_i2c_target;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_bus;
  logic sda_pull_o;
  logic [1:0] addr_pins_i = 2'd0;
  logic [7:0] wiper_i = 8'h00;
  logic [1:0] status_i = 2'd0;
  logic trim_sel_o, shutdown_o, fuse_prog_o, overwrite_o, instr_valid_o, wdata_valid_o;
  logic [7:0] wdata_o;

  int n_chk = 0, n_fail = 0, n_i = 0, n_w = 0;
  logic [7:0] last_w = 8'h00;
  logic pull_seen = 1'b0;
  logic glitch_en = 1'b0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull_o;

  wiper_i2c_target i_wiper_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_pull_o(sda_pull_o),
    .addr_pins_i(addr_pins_i), .wiper_i(wiper_i), .status_i(status_i),
    .trim_sel_o(trim_sel_o), .shutdown_o(shutdown_o), .fuse_prog_o(fuse_prog_o),
    .overwrite_o(overwrite_o), .instr_valid_o(instr_valid_o), .wdata_o(wdata_o),
    .wdata_valid_o(wdata_valid_o));

  always @(negedge clk) begin
    if (wdata_valid_o) begin n_w++; last_w = wdata_o; end
    if (instr_valid_o) n_i++;
    if (sda_pull_o) pull_seen = 1'b1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic xfer_bit(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2);
    if (glitch_en) begin
      sda_m = ~b; tick(1);
      sda_m = b;  tick(2);
      scl_m = 1'b0; tick(1);
      scl_m = 1'b1;
    end
    tick(Q);
    r = sda_bus;
    tick(2);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) xfer_bit(d[i], r);
    xfer_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(1'b1, r);
      d[i] = r;
    end
    xfer_bit(~mack, r);
  endtask

  function automatic logic [3:0] fields_of(input logic [7:0] ins);
    return {ins[7], ins[6], ins[5], ins[3]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    logic [3:0] exp_f;
    int i0, w0;

    tick(4);
    // R9 reset state
    chk("R9 pull", sda_pull_o, 0);
    chk("R9 strobes", {instr_valid_o, wdata_valid_o}, 0);
    chk("R9 fields", {trim_sel_o, shutdown_o, fuse_prog_o, overwrite_o}, 0);
    chk("R9 wdata", wdata_o, 0);
    rst_n = 1'b1;
    tick(10);
    exp_f = 4'h0;

    // R1 address sweep against each strap setting
    for (int p = 0; p < 4; p++) begin
      addr_pins_i = 2'(p);
      for (int a = 0; a < 128; a++) begin
        logic match;
        if (!((a[6:2] == 5'b01011) || (a[1:0] == p[1:0]))) continue;
        match = (a[6:2] == 5'b01011) && (a[1:0] == p[1:0]);
        i0 = n_i;
        pull_seen = 1'b0;
        bus_start();
        send_byte({a[6:0], 1'b0}, ack);
        chk("R1 address ack", ack, match);
        send_byte(8'h00, ack);
        if (match) begin
          exp_f = 4'h0;
          chk("R1 matched instr ack", ack, 1);
          chk("R1 matched instr strobe", n_i - i0, 1);
        end else begin
          chk("R1 ignored byte ack", ack, 0);
          chk("R1 ignored byte strobe", n_i - i0, 0);
          chk("R7 no pull when not addressed", pull_seen, 0);
        end
        bus_stop();
      end
    end
    addr_pins_i = 2'd2;

    // R2 R3 R4 instruction sweep over upper five bits
    for (int k = 0; k < 32; k++) begin
      logic [7:0] ins, dat;
      ins = {k[4:0], k[2:0] ^ 3'b101};
      dat = 8'(k * 9 + 1);
      i0 = n_i; w0 = n_w;
      bus_start();
      send_byte({5'b01011, 2'd2, 1'b0}, ack);
      send_byte(ins, ack);
      chk("R2 instr ack", ack, 1);
      send_byte(dat, ack);
      chk("R4 data ack", ack, 1);
      bus_stop();
      if (!ins[4]) begin
        exp_f = fields_of(ins);
        chk("R2 instr strobe", n_i - i0, 1);
        chk("R4 data strobe", n_w - w0, 1);
        chk("R4 data value", last_w, dat);
      end else begin
        chk("R3 no instr strobe", n_i - i0, 0);
        chk("R3 no data strobe", n_w - w0, 0);
      end
      chk("R2 fields", {trim_sel_o, shutdown_o, fuse_prog_o, overwrite_o}, exp_f);
    end

    // R4 several data bytes in one frame
    begin
      logic [7:0] seq [4] = '{8'h00, 8'hFF, 8'h5A, 8'hA5};
      i0 = n_i; w0 = n_w;
      bus_start();
      send_byte({5'b01011, 2'd2, 1'b0}, ack);
      send_byte(8'h88, ack);
      exp_f = fields_of(8'h88);
      for (int j = 0; j < 4; j++) begin
        send_byte(seq[j], ack);
        chk("R4 burst ack", ack, 1);
        chk("R4 burst count", n_w - w0, j + 1);
        chk("R4 burst value", last_w, seq[j]);
      end
      bus_stop();
      chk("R2 burst fields", {trim_sel_o, shutdown_o, fuse_prog_o, overwrite_o}, exp_f);
    end

    // R5 reads over all status codes
    for (int s = 0; s < 4; s++) begin
      logic [7:0] wv;
      wv = 8'(s * 8'h55) ^ 8'hA3;
      wiper_i = wv;
      status_i = 2'(s);
      bus_start();
      send_byte({5'b01011, 2'd2, 1'b1}, ack);
      chk("R5 read addr ack", ack, 1);
      read_byte(1'b1, rd);
      chk("R5 wiper byte", rd, wv);
      wiper_i = wv ^ 8'h0F;
      read_byte(1'b1, rd);
      chk("R5 status byte", rd, {2'(s), 6'b0});
      read_byte(1'b0, rd);
      chk("R5 repeated wiper", rd, wv ^ 8'h0F);
      chk("R5 released after nack", sda_pull_o, 0);
      bus_stop();
      chk("R7 released after stop", sda_pull_o, 0);
    end

    // R6 repeated start inside a data byte
    begin
      logic r;
      w0 = n_w;
      bus_start();
      send_byte({5'b01011, 2'd2, 1'b0}, ack);
      send_byte(8'h00, ack);
      for (int j = 0; j < 4; j++) xfer_bit(1'b1, r);
      bus_start();
      chk("R6 partial byte on start", n_w - w0, 0);
      send_byte({5'b01011, 2'd2, 1'b0}, ack);
      chk("R6 address after restart", ack, 1);
      send_byte(8'h40, ack);
      send_byte(8'h77, ack);
      bus_stop();
      chk("R6 frame after restart", n_w - w0, 1);
      chk("R6 value after restart", last_w, 8'h77);
      exp_f = fields_of(8'h40);
      chk("R6 fields after restart", {trim_sel_o, shutdown_o, fuse_prog_o, overwrite_o}, exp_f);

      // R6 stop inside a data byte
      w0 = n_w;
      bus_start();
      send_byte({5'b01011, 2'd2, 1'b0}, ack);
      send_byte(8'h00, ack);
      exp_f = 4'h0;
      for (int j = 0; j < 5; j++) xfer_bit(1'b0, r);
      bus_stop();
      chk("R6 partial byte on stop", n_w - w0, 0);
    end

    // R8 single-cycle glitches on both lines
    glitch_en = 1'b1;
    i0 = n_i; w0 = n_w;
    bus_start();
    send_byte({5'b01011, 2'd2, 1'b0}, ack);
    chk("R8 addr ack with glitches", ack, 1);
    send_byte(8'h20, ack);
    send_byte(8'hC3, ack);
    chk("R8 data ack with glitches", ack, 1);
    glitch_en = 1'b0;
    bus_stop();
    chk("R8 instr strobe count", n_i - i0, 1);
    chk("R8 data strobe count", n_w - w0, 1);
    chk("R8 data value", last_w, 8'hC3);
    chk("R8 fields", {trim_sel_o, shutdown_o, fuse_prog_o, overwrite_o}, fields_of(8'h20));

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule